// File: doc/BRIEF.md
# Permanent Lower-Half Write-Protect Controller

This block sits behind the serial slave front end of a 256-byte nonvolatile store. It decides two things: whether a given byte write may change memory, and how the slave answers the special protection command. The front end decodes bus traffic into single-cycle events and passes them in: a start, a stop, a received slave-address byte and a received follow-on byte.

The controller keeps a one-time lock flag. While the flag is clear, a write-form protection command arms it. That command is an address byte carrying code 0110 and the matching strap bits, then two don't-care bytes, then a stop, with the write-protect pin low for the whole command. A simulated programming cycle follows. The slave stays busy during that cycle, and the flag latches when the cycle ends.

Once latched, the flag refuses writes to the lower half (00h-7Fh) for good. The write-protect pin, when high, refuses every write. The flag comes out of reset from an input that stands in for the stored cell value.

Top module: `wp_lock_ctrl`

## Requirements
- R1: With the lock flag set, `wr_en_o` stays 0 for any address with bit 7 clear (00h-7Fh), whatever the pin level. With the pin low, addresses with bit 7 set (80h-FFh) still get `wr_en_o` = `wr_req_i`.
- R2: While `wp_pin_i` is 1, `wr_en_o` is 0 for every address.
- R3: The slave-address byte is laid out as bits 7:4 = command code, bits 3:1 = strap, bit 0 = direction (1 = read). A byte with code 0110 and a strap equal to `strap_i` gets `ack_o` = 1 in the cycle of `addr_valid_i`, but only when the lock flag is clear and `busy_o` is 0. Any other code, a strap mismatch, a set flag or a busy slave gives `ack_o` = 0.
- R4: A complete write-form command ends with its stop. `busy_o` rises in the cycle after that stop and stays high for exactly WRITE_CYCLES clock cycles.
- R5: `lock_o` goes to 1 on the same clock edge at which `busy_o` falls, and not before. After that it never returns to 0 until the next reset.
- R6: A read-form protection address (direction bit 1) is only a status query. It is acknowledged per R3, and neither `busy_o` nor `lock_o` changes because of it or the stop after it.
- R7: A start received anywhere inside the command sequence abandons it. A later stop then starts no write cycle.
- R8: If `wp_pin_i` is 1 at any event of the sequence (address, either dummy byte, or the stop), the stop starts no write cycle.
- R9: During reset `lock_o` takes the value of `lock_init_i`, and `busy_o` is 0.
- R10: Inside an accepted write-form command, the first and second follow-on bytes each get `ack_o` = 1 in their `byte_valid_i` cycle. A follow-on byte outside such a command gets `ack_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lock_init_i | input | 1 | Stored lock value loaded at reset |
| wp_pin_i | input | 1 | Hardware write-protect level |
| strap_i | input | 3 | Device strap address |
| start_i | input | 1 | Start condition event |
| stop_i | input | 1 | Stop condition event |
| addr_valid_i | input | 1 | Slave-address byte received |
| addr_byte_i | input | 8 | Received slave-address byte |
| byte_valid_i | input | 1 | Follow-on byte received |
| wr_req_i | input | 1 | Normal memory byte write request |
| wr_addr_i | input | 8 | Memory address of that write |
| ack_o | output | 1 | Acknowledge decision for the current protection-command byte |
| busy_o | output | 1 | Programming cycle in progress |
| lock_o | output | 1 | Lock flag |
| wr_en_o | output | 1 | Write enable for the addressed byte |

## Verification
The assertions take for granted that the front end raises at most one of `start_i`, `stop_i`, `addr_valid_i` and `byte_valid_i` in any cycle, and that each event lasts one cycle. The stimulus tasks raise exactly one pulse and drop it on the next cycle, so that condition always holds. The pin, strap and write probe are changed only a small delay after a clock edge and are held for full cycles. The command and status paths are checked with the pin both low and high, and with sequences that are cut short or malformed.

// File: rtl/wp_lock_pkg.sv
package wp_lock_pkg;
  localparam int BYTE_W  = 8;
  localparam int CODE_W  = 4;
  localparam int STRAP_W = 3;
  localparam logic [CODE_W-1:0] CMD_CODE = 4'b0110;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ADDR,
    SEQ_WORD,
    SEQ_DATA
  } seq_state_e;
endpackage

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq
  import wp_lock_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wp_pin_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               addr_valid_i,
  input  logic [BYTE_W-1:0]  addr_byte_i,
  input  logic               byte_valid_i,
  input  logic               locked_i,
  input  logic               busy_i,
  output logic               ack_o,
  output logic               fire_o
);
  seq_state_e state_q, state_d;
  logic       wp_ok_q, wp_ok_d;
  logic       cmd_hit, addr_ack, byte_ack, is_read;

  assign is_read  = addr_byte_i[0];
  assign cmd_hit  = (addr_byte_i[BYTE_W-1 -: CODE_W] == CMD_CODE) &&
                    (addr_byte_i[STRAP_W:1] == strap_i);
  assign addr_ack = addr_valid_i && cmd_hit && !locked_i && !busy_i;
  assign byte_ack = byte_valid_i && (state_q == SEQ_ADDR || state_q == SEQ_WORD);
  assign ack_o    = addr_ack || byte_ack;
  assign fire_o   = !start_i && stop_i && (state_q == SEQ_DATA) && wp_ok_q && !wp_pin_i;

  always_comb begin
    state_d = state_q;
    wp_ok_d = wp_ok_q;
    if (start_i || stop_i) begin
      state_d = SEQ_IDLE;
    end else if (addr_valid_i) begin
      state_d = (addr_ack && !is_read) ? SEQ_ADDR : SEQ_IDLE;
      wp_ok_d = !wp_pin_i;
    end else if (byte_valid_i) begin
      wp_ok_d = wp_ok_q && !wp_pin_i;
      unique case (state_q)
        SEQ_ADDR: state_d = SEQ_WORD;
        SEQ_WORD: state_d = SEQ_DATA;
        default:  state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      wp_ok_q <= 1'b0;
    end else begin
      state_q <= state_d;
      wp_ok_q <= wp_ok_d;
    end
  end

  a_r7_start_abandons: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == SEQ_IDLE));
  a_r8_fire_needs_pin_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> !wp_pin_i);
  a_r3_no_ack_when_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && addr_valid_i) |-> !ack_o);
  a_r3_no_ack_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && addr_valid_i) |-> !ack_o);
endmodule

// File: rtl/wp_cycle_timer.sv
module wp_cycle_timer #(
  parameter int unsigned WRITE_CYCLES = 20,
  localparam int unsigned CNT_W = $clog2(WRITE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic busy_o,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (busy_o)  cnt_q <= cnt_q - CNT_W'(1);
    else if (fire_i)  cnt_q <= CNT_W'(WRITE_CYCLES);
  end

  a_r4_busy_after_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !busy_o) |=> busy_o);
  a_r5_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/wp_lock_reg.sv
module wp_lock_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic set_i,
  output logic locked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    locked_o <= init_i;
    else if (set_i) locked_o <= 1'b1;
  end

  a_r5_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);
  a_r5_set_only_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(set_i));
endmodule

// File: rtl/wp_lock_ctrl.sv
module wp_lock_ctrl
  import wp_lock_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES = 20,
  parameter int unsigned MEM_AW       = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lock_init_i,
  input  logic               wp_pin_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               addr_valid_i,
  input  logic [BYTE_W-1:0]  addr_byte_i,
  input  logic               byte_valid_i,
  input  logic               wr_req_i,
  input  logic [MEM_AW-1:0]  wr_addr_i,
  output logic               ack_o,
  output logic               busy_o,
  output logic               lock_o,
  output logic               wr_en_o
);
  logic fire, done, lower_half;

  wp_cmd_seq u_seq (
    .clk_i, .rst_ni, .strap_i, .wp_pin_i, .start_i, .stop_i,
    .addr_valid_i, .addr_byte_i, .byte_valid_i,
    .locked_i (lock_o),
    .busy_i   (busy_o),
    .ack_o,
    .fire_o   (fire)
  );

  wp_cycle_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk_i, .rst_ni,
    .fire_i (fire),
    .busy_o,
    .done_o (done)
  );

  wp_lock_reg u_lock (
    .clk_i, .rst_ni,
    .init_i   (lock_init_i),
    .set_i    (done),
    .locked_o (lock_o)
  );

  assign lower_half = !wr_addr_i[MEM_AW-1];
  assign wr_en_o    = wr_req_i && !wp_pin_i && !(lock_o && lower_half);

  a_r1_lower_half_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !wr_addr_i[MEM_AW-1]) |-> !wr_en_o);
  a_r2_pin_blocks_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_pin_i |-> !wr_en_o);
  a_r6_query_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && addr_byte_i[0] && !stop_i && !busy_o) |=> !busy_o);
endmodule

// File: tb/wp_lock_ctrl_tb.sv
`timescale 1ns/1ps
module wp_lock_ctrl_tb;
  localparam int N = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lock_init = 1'b0;
  logic       wp = 1'b0;
  logic [2:0] strap = 3'd5;
  logic       start = 0, stop = 0, addr_valid = 0, byte_valid = 0, wr_req = 0;
  logic [7:0] addr_byte = 8'h00, wr_addr = 8'h00;
  logic       ack, busy, lock, wr_en;

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  wp_lock_ctrl #(.WRITE_CYCLES(N), .MEM_AW(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lock_init_i(lock_init), .wp_pin_i(wp),
    .strap_i(strap), .start_i(start), .stop_i(stop),
    .addr_valid_i(addr_valid), .addr_byte_i(addr_byte), .byte_valid_i(byte_valid),
    .wr_req_i(wr_req), .wr_addr_i(wr_addr),
    .ack_o(ack), .busy_o(busy), .lock_o(lock), .wr_en_o(wr_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit m_lock, m_wp_ok;
  int m_cnt, m_phase;

  function automatic bit m_ack();
    bit hit;
    hit = (addr_byte[7:4] == 4'b0110) && (addr_byte[3:1] == strap);
    return (addr_valid && hit && !m_lock && m_cnt == 0) ||
           (byte_valid && (m_phase == 1 || m_phase == 2));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lock = lock_init; m_cnt = 0; m_phase = 0; m_wp_ok = 0;
    end else begin
      bit a;
      a = m_ack();
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) m_lock = 1;
      end else if (stop && !start && m_phase == 3 && m_wp_ok && !wp) begin
        m_cnt = N;
      end
      if (start || stop) m_phase = 0;
      else if (addr_valid) begin
        m_phase = (a && !addr_byte[0]) ? 1 : 0;
        m_wp_ok = !wp;
      end else if (byte_valid) begin
        m_wp_ok = m_wp_ok && !wp;
        m_phase = (m_phase == 1 || m_phase == 2) ? m_phase + 1 : 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_wr;
      e_wr = wr_req && !wp && !(m_lock && wr_addr < 8'h80);
      check(ack == m_ack(), "R3 ack vs model", ack, m_ack());
      check(busy == (m_cnt > 0), "R4 busy vs model", busy, m_cnt > 0);
      check(lock == m_lock, "R5 lock vs model", lock, m_lock);
      check(wr_en == e_wr, "R1 wr_en vs model", wr_en, e_wr);
    end
  end

  // one-cycle stimulus helpers; each leaves the bus idle
  task automatic tick(); @(posedge clk); #1; endtask

  task automatic ev_start(); start = 1; tick(); start = 0; endtask
  task automatic ev_stop();  stop = 1;  tick(); stop = 0;  endtask

  task automatic ev_addr(input logic [3:0] code, input logic [2:0] s, input bit rd,
                         input string req, input bit exp_ack);
    addr_byte = {code, s, rd}; addr_valid = 1;
    @(negedge clk); check(ack == exp_ack, req, ack, exp_ack);
    tick(); addr_valid = 0;
  endtask

  task automatic ev_byte(input string req, input bit exp_ack);
    byte_valid = 1;
    @(negedge clk); check(ack == exp_ack, req, ack, exp_ack);
    tick(); byte_valid = 0;
  endtask

  task automatic probe(input logic [7:0] a, input string req, input bit exp);
    wr_addr = a; wr_req = 1;
    @(negedge clk); check(wr_en == exp, req, wr_en, exp);
    tick(); wr_req = 0;
  endtask

  task automatic do_reset(input bit init);
    lock_init = init; rst_n = 0;
    repeat (2) tick();
    @(negedge clk); check(lock == init, "R9 lock reset value", lock, init);
    check(busy == 0, "R9 busy at reset", busy, 0);
    rst_n = 1; tick();
  endtask

  initial begin
    #300000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick();
    do_reset(1'b0);

    // R1/R2 with lock clear
    probe(8'h10, "R1 lower half open before lock", 1);
    wp = 1; probe(8'hF0, "R2 pin high blocks upper", 0);
    probe(8'h05, "R2 pin high blocks lower", 0); wp = 0;

    // R3/R6 status query
    ev_start(); ev_addr(4'b0110, 3'd5, 1, "R3 query acked while clear", 1); ev_stop();
    repeat (3) tick();
    @(negedge clk); check(busy == 0 && lock == 0, "R6 query inert", {busy, lock}, 0);
    ev_start(); ev_addr(4'b0110, 3'd2, 0, "R3 strap mismatch", 0); ev_stop();
    ev_start(); ev_addr(4'b1010, 3'd5, 0, "R3 other code", 0); ev_stop();
    ev_byte("R10 stray byte not acked", 0);

    // R7 abort by start
    ev_start(); ev_addr(4'b0110, 3'd5, 0, "R3 write-form acked", 1);
    ev_byte("R10 word byte acked", 1);
    ev_start();
    ev_byte("R7 byte after restart not acked", 0);
    ev_stop(); tick();
    @(negedge clk); check(busy == 0, "R7 aborted command idle", busy, 0);

    // R8 pin high on data byte
    ev_start(); ev_addr(4'b0110, 3'd5, 0, "R3 write-form acked", 1);
    ev_byte("R10 word byte acked", 1);
    wp = 1; ev_byte("R10 data byte acked", 1); wp = 0;
    ev_stop(); tick();
    @(negedge clk); check(busy == 0, "R8 pin high suppresses set", busy, 0);

    // R4/R5 full command
    ev_start(); ev_addr(4'b0110, 3'd5, 0, "R3 write-form acked", 1);
    ev_byte("R10 word byte acked", 1);
    ev_byte("R10 data byte acked", 1);
    ev_stop();
    @(negedge clk); check(busy == 1, "R4 busy after stop", busy, 1);
    check(lock == 0, "R5 lock not at stop", lock, 0);
    ev_start(); ev_addr(4'b0110, 3'd5, 1, "R3 no ack while busy", 0); ev_stop();
    repeat (N - 4) tick();
    @(negedge clk); check(busy == 1 && lock == 0, "R4 busy window last cycle", {busy, lock}, 2);
    tick();
    @(negedge clk); check(busy == 0, "R4 busy ends after N", busy, 0);
    check(lock == 1, "R5 lock at busy end", lock, 1);

    // after lock
    ev_start(); ev_addr(4'b0110, 3'd5, 1, "R3 no ack once locked", 0); ev_stop();
    ev_start(); ev_addr(4'b0110, 3'd5, 0, "R3 write-form refused once locked", 0); ev_stop();
    probe(8'h7F, "R1 top of lower half blocked", 0);
    probe(8'h00, "R1 bottom blocked", 0);
    probe(8'h80, "R1 upper half open", 1);
    wp = 1; probe(8'hC3, "R2 pin high with lock", 0); wp = 0;
    repeat (5) tick();
    @(negedge clk); check(lock == 1, "R5 lock sticky", lock, 1);

    do_reset(1'b1);
    probe(8'h22, "R1 lower blocked from stored lock", 0);
    do_reset(1'b0);
    probe(8'h22, "R1 lower open from stored clear", 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule